// File: doc/BRIEF.md
# Single-Cycle Load/Store Integer Core

This block is a compact 32-bit processor that completes one instruction per clock edge. Each instruction is fetched from a word array inside the block and decoded into a small set of control strobes. Those strobes steer a datapath built from a 32-entry register file, an adder-based ALU, a byte-addressed data store and the program counter. The instruction set is a fixed three-format subset of a classic load/store architecture. It covers register arithmetic, signed compare, immediate arithmetic and logic, upper-half constant loads, word loads and stores, conditional branches, direct jumps, call-with-link and register-indirect jumps.

The program is written through a word-wide load port, normally while reset is held. Once reset is released, execution starts at address 0. A debug port selects one register and drives its value out, and it also shows the current program counter. A test environment can therefore compare the architectural state with its own model.

Top module: `tinyRiscCore`

## Requirements
- R1: A synchronous reset sets the PC to 0. Any instruction that is not a taken branch or a jump advances the PC by exactly 4 on the next rising edge, and the PC is always word aligned.
- R2: With opcode 0, funct 32 writes rs+rt into the rd register and funct 34 writes rs−rt into rd (R-type fields from bit 31 down: op 6, rs 5, rt 5, rd 5, shamt 5, funct 6).
- R3: slt (op 0, funct 42) and slti (op 10) write 1 to the destination when the first operand is less than the second as signed 32-bit values, and write 0 otherwise.
- R4: I-type instructions (op, rs, rt, imm16) write to rt. addi (op 8) uses the sign-extended immediate, ori (op 13) ORs rs with the zero-extended immediate, and lui (op 15) writes imm16 to bits 31:16 and zero to bits 15:0.
- R5: lw (op 35) and sw (op 43) use the byte address rs + sign-extended imm16. A word occupies four consecutive bytes, most significant byte at the lowest address.
- R6: Register 0 always reads as zero, and a write aimed at it is discarded.
- R7: beq (op 4) and bne (op 5) branch to PC+4 + (sign-extended imm16 << 2) when rs equals rt (beq) or differs from it (bne). Otherwise they fall through to PC+4.
- R8: j (op 2) and jal (op 3) jump to {PC+4[31:28], target26, 00}, and jal also writes PC+4 into register 31.
- R9: jr (op 0, funct 8) loads the PC from the rs register.
- R10: An undefined opcode, or opcode 0 with an undefined funct, changes no register and no memory and only advances the PC by 4.
- R11: The debug output shows the register chosen by the debug select combinationally, and the PC output shows the address of the instruction being executed.
- R12: An asserted instruction write enable stores the word at the given word index of the instruction array on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imemWe | input | 1 | Instruction array write enable |
| imemAddr | input | IMEM_ADDR_W (6) | Word index for the instruction write |
| imemData | input | 32 | Instruction word to store |
| dbgRegSel | input | 5 | Register chosen for the debug output |
| dbgRegData | output | 32 | Value of the selected register |
| pcOut | output | 32 | Current program counter |

## Verification
Every instruction retires on the rising edge that follows its fetch. After the k-th edge following reset release, the PC output therefore shows the k-th address of the expected execution path. The bench samples it at each falling edge, starting with the reset value at the moment reset is released. A queue of expected addresses is consumed one per falling edge, so any extra or missing cycle of a branch, jump or no-op shows up as a mismatch at that exact point. Register results are combinational on the debug port. They are read only after the program has settled into its closing self-loop, with each select change given a short settle time before sampling.

// File: rtl/cpuPkg.sv
package cpuPkg;

  localparam int XLEN = 32;

  // primary opcodes
  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_J     = 6'd2;
  localparam logic [5:0] OP_JAL   = 6'd3;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_BNE   = 6'd5;
  localparam logic [5:0] OP_ADDI  = 6'd8;
  localparam logic [5:0] OP_SLTI  = 6'd10;
  localparam logic [5:0] OP_ORI   = 6'd13;
  localparam logic [5:0] OP_LUI   = 6'd15;
  localparam logic [5:0] OP_LW    = 6'd35;
  localparam logic [5:0] OP_SW    = 6'd43;

  // function codes under OP_RTYPE
  localparam logic [5:0] FN_JR  = 6'd8;
  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_SLT,
    ALU_OR,
    ALU_UPPER
  } aluOp_e;

  typedef struct packed {
    logic   regWrite;
    logic   regDstRd;
    logic   aluSrcImm;
    logic   immZeroExt;
    aluOp_e aluOp;
    logic   memRead;
    logic   memWrite;
    logic   branchEq;
    logic   branchNe;
    logic   jump;
    logic   link;
    logic   jumpReg;
    logic   illegal;
  } ctrl_t;

endpackage

// File: rtl/cpuControl.sv
module cpuControl
  import cpuPkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl          = '0;
    ctrl.aluOp    = ALU_ADD;
    ctrl.illegal  = 1'b0;
    unique case (opcode)
      OP_RTYPE: begin
        unique case (funct)
          FN_ADD: begin ctrl.regWrite = 1'b1; ctrl.regDstRd = 1'b1; ctrl.aluOp = ALU_ADD; end
          FN_SUB: begin ctrl.regWrite = 1'b1; ctrl.regDstRd = 1'b1; ctrl.aluOp = ALU_SUB; end
          FN_SLT: begin ctrl.regWrite = 1'b1; ctrl.regDstRd = 1'b1; ctrl.aluOp = ALU_SLT; end
          FN_JR:  ctrl.jumpReg = 1'b1;
          default: ctrl.illegal = 1'b1;
        endcase
      end
      OP_ADDI: begin ctrl.regWrite = 1'b1; ctrl.aluSrcImm = 1'b1; ctrl.aluOp = ALU_ADD; end
      OP_SLTI: begin ctrl.regWrite = 1'b1; ctrl.aluSrcImm = 1'b1; ctrl.aluOp = ALU_SLT; end
      OP_ORI: begin
        ctrl.regWrite   = 1'b1;
        ctrl.aluSrcImm  = 1'b1;
        ctrl.immZeroExt = 1'b1;
        ctrl.aluOp      = ALU_OR;
      end
      OP_LUI: begin ctrl.regWrite = 1'b1; ctrl.aluSrcImm = 1'b1; ctrl.aluOp = ALU_UPPER; end
      OP_LW: begin
        ctrl.regWrite  = 1'b1;
        ctrl.aluSrcImm = 1'b1;
        ctrl.memRead   = 1'b1;
      end
      OP_SW: begin ctrl.aluSrcImm = 1'b1; ctrl.memWrite = 1'b1; end
      OP_BEQ: ctrl.branchEq = 1'b1;
      OP_BNE: ctrl.branchNe = 1'b1;
      OP_J:   ctrl.jump = 1'b1;
      OP_JAL: begin ctrl.jump = 1'b1; ctrl.link = 1'b1; ctrl.regWrite = 1'b1; end
      default: ctrl.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/cpuDatapath.sv
module cpuDatapath
  import cpuPkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_BYTES = 256,
  localparam int IA = $clog2(IMEM_WORDS),
  localparam int DA = $clog2(DMEM_BYTES),
  localparam int NREG = 32,
  localparam int LINK_REG = NREG - 1
) (
  input  logic            clk,
  input  logic            rst,
  input  ctrl_t           ctrl,
  input  logic            imemWe,
  input  logic [IA-1:0]   imemAddr,
  input  logic [XLEN-1:0] imemData,
  input  logic [4:0]      dbgRegSel,
  output logic [XLEN-1:0] dbgRegData,
  output logic [XLEN-1:0] pcOut,
  output logic [5:0]      opcode,
  output logic [5:0]      funct
);

  logic [XLEN-1:0] pc, pcNext, pcPlus4, brTarget, jmpTarget;
  logic [XLEN-1:0] instr;
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] regFile [NREG];
  logic [7:0]      dmem [DMEM_BYTES];

  logic [4:0]      rsIdx, rtIdx, rdIdx, wrIdx;
  logic [15:0]     imm16;
  logic [25:0]     target26;
  logic [XLEN-1:0] rsVal, rtVal, immExt, opB, aluResult, loadWord, wrData;
  logic [XLEN-1:0] diff;
  logic            takeBranch, isEqual, signedLess;
  logic [DA-1:0]   wordBase;

  // fetch and field split
  assign instr    = imem[pc[IA+1:2]];
  assign opcode   = instr[31:26];
  assign rsIdx    = instr[25:21];
  assign rtIdx    = instr[20:16];
  assign rdIdx    = instr[15:11];
  assign funct    = instr[5:0];
  assign imm16    = instr[15:0];
  assign target26 = instr[25:0];

  always_ff @(posedge clk) begin
    if (imemWe) imem[imemAddr] <= imemData;
  end

  // register file: combinational read, register 0 hard-wired
  assign rsVal = regFile[rsIdx];
  assign rtVal = regFile[rtIdx];
  assign dbgRegData = regFile[dbgRegSel];

  always_comb begin
    if (ctrl.link)          wrIdx = 5'(LINK_REG);
    else if (ctrl.regDstRd) wrIdx = rdIdx;
    else                    wrIdx = rtIdx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regFile[i] <= '0;
    end else if (ctrl.regWrite && wrIdx != 5'd0) begin
      regFile[wrIdx] <= wrData;
    end
  end

  // ALU
  assign immExt = ctrl.immZeroExt ? {16'b0, imm16} : {{16{imm16[15]}}, imm16};
  assign opB    = ctrl.aluSrcImm ? immExt : rtVal;
  assign diff   = rsVal - opB;
  assign signedLess = (rsVal[31] != opB[31]) ? rsVal[31] : diff[31];

  always_comb begin
    unique case (ctrl.aluOp)
      ALU_SUB:   aluResult = diff;
      ALU_SLT:   aluResult = {31'b0, signedLess};
      ALU_OR:    aluResult = rsVal | opB;
      ALU_UPPER: aluResult = {imm16, 16'b0};
      default:   aluResult = rsVal + opB;
    endcase
  end

  // data memory: bytes, most significant byte at the lowest address
  assign wordBase = {aluResult[DA-1:2], 2'b00};
  assign loadWord = {dmem[wordBase], dmem[wordBase + DA'(1)],
                     dmem[wordBase + DA'(2)], dmem[wordBase + DA'(3)]};

  always_ff @(posedge clk) begin
    if (!rst && ctrl.memWrite) begin
      dmem[wordBase]          <= rtVal[31:24];
      dmem[wordBase + DA'(1)] <= rtVal[23:16];
      dmem[wordBase + DA'(2)] <= rtVal[15:8];
      dmem[wordBase + DA'(3)] <= rtVal[7:0];
    end
  end

  always_comb begin
    if (ctrl.link)         wrData = pcPlus4;
    else if (ctrl.memRead) wrData = loadWord;
    else                   wrData = aluResult;
  end

  // next PC
  assign pcPlus4    = pc + 32'd4;
  assign brTarget   = pcPlus4 + {{14{imm16[15]}}, imm16, 2'b00};
  assign jmpTarget  = {pcPlus4[31:28], target26, 2'b00};
  assign isEqual    = (rsVal == rtVal);
  assign takeBranch = (ctrl.branchEq && isEqual) || (ctrl.branchNe && !isEqual);

  always_comb begin
    if (ctrl.jumpReg)   pcNext = {rsVal[31:2], 2'b00};
    else if (ctrl.jump) pcNext = jmpTarget;
    else if (takeBranch) pcNext = brTarget;
    else                pcNext = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pcNext;
  end

  assign pcOut = pc;

  // assertions
  assert_pc_aligned_R1: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00);

  assert_seq_advance_R1: assert property (@(posedge clk) disable iff (rst)
    !(ctrl.jump || ctrl.jumpReg || ctrl.branchEq || ctrl.branchNe) |=> pc == $past(pc) + 32'd4);

  assert_zero_reg_R6: assert property (@(posedge clk) disable iff (rst)
    regFile[0] == '0);

  assert_branch_fallthru_R7: assert property (@(posedge clk) disable iff (rst)
    (ctrl.branchEq && rsVal != rtVal) |=> pc == $past(pc) + 32'd4);

  assert_link_value_R8: assert property (@(posedge clk) disable iff (rst)
    ctrl.link |=> regFile[LINK_REG] == $past(pc) + 32'd4);

  assert_illegal_noop_R10: assert property (@(posedge clk) disable iff (rst)
    ctrl.illegal |=> (pc == $past(pc) + 32'd4) && $stable(regFile[1]) && $stable(regFile[17]));

endmodule

// File: rtl/tinyRiscCore.sv
module tinyRiscCore
  import cpuPkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_BYTES = 256,
  localparam int IMEM_ADDR_W = $clog2(IMEM_WORDS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   imemWe,
  input  logic [IMEM_ADDR_W-1:0] imemAddr,
  input  logic [31:0]            imemData,
  input  logic [4:0]             dbgRegSel,
  output logic [31:0]            dbgRegData,
  output logic [31:0]            pcOut
);

  ctrl_t      ctrl;
  logic [5:0] opcode, funct;

  cpuControl uCtrl (
    .opcode (opcode),
    .funct  (funct),
    .ctrl   (ctrl)
  );

  cpuDatapath #(
    .IMEM_WORDS (IMEM_WORDS),
    .DMEM_BYTES (DMEM_BYTES)
  ) uPath (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl),
    .imemWe     (imemWe),
    .imemAddr   (imemAddr),
    .imemData   (imemData),
    .dbgRegSel  (dbgRegSel),
    .dbgRegData (dbgRegData),
    .pcOut      (pcOut),
    .opcode     (opcode),
    .funct      (funct)
  );

  assert_jr_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    ctrl.jumpReg |-> !ctrl.regWrite && !ctrl.memWrite);

endmodule

// File: tb/sim_tinyRiscCore.sv
module sim_tinyRiscCore;

  localparam int IMEM_WORDS = 64;
  localparam int IA = $clog2(IMEM_WORDS);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          imemWe = 1'b0;
  logic [IA-1:0] imemAddr = '0;
  logic [31:0]   imemData = '0;
  logic [4:0]    dbgRegSel = '0;
  logic [31:0]   dbgRegData, pcOut;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    int          idx;
    logic [31:0] val;
    string       tag;
  } item_t;

  item_t pcQ[$];
  item_t regQ[$];

  always #10 clk = ~clk;

  tinyRiscCore #(.IMEM_WORDS(IMEM_WORDS), .DMEM_BYTES(256)) u0 (
    .clk(clk), .rst(rst), .imemWe(imemWe), .imemAddr(imemAddr),
    .imemData(imemData), .dbgRegSel(dbgRegSel),
    .dbgRegData(dbgRegData), .pcOut(pcOut)
  );

  function automatic logic [31:0] encR(int rs, int rt, int rd, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction
  function automatic logic [31:0] encI(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] encJ(int op, int tgt);
    return {6'(op), 26'(tgt)};
  endfunction

  task automatic compare(string what, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic writeInstr(int addr, logic [31:0] word);
    @(negedge clk);
    imemWe   = 1'b1;
    imemAddr = IA'(addr);
    imemData = word;
  endtask

  task automatic pushPc(int wordIdx, string tag);
    item_t it;
    it.idx = wordIdx; it.val = 32'(wordIdx * 4); it.tag = tag;
    pcQ.push_back(it);
  endtask

  task automatic pushReg(int r, logic [31:0] v, string tag);
    item_t it;
    it.idx = r; it.val = v; it.tag = tag;
    regQ.push_back(it);
  endtask

  // driver: program load (R12) and expected results
  task automatic loadProgram();
    for (int i = 0; i < IMEM_WORDS; i++) writeInstr(i, 32'h0);
    writeInstr(0,  encI(8, 0, 1, 5));          // addi r1,r0,5
    writeInstr(1,  encI(8, 0, 2, -3));         // addi r2,r0,-3
    writeInstr(2,  encR(1, 2, 3, 32));         // add r3
    writeInstr(3,  encR(2, 1, 4, 34));         // sub r4 = r2-r1
    writeInstr(4,  encR(2, 1, 5, 42));         // slt r5
    writeInstr(5,  encR(1, 2, 6, 42));         // slt r6
    writeInstr(6,  encI(10, 2, 7, -2));        // slti r7
    writeInstr(7,  encI(15, 0, 8, 16'h1234));  // lui r8
    writeInstr(8,  encI(13, 8, 8, 16'h8765));  // ori r8
    writeInstr(9,  encI(43, 0, 8, 8));         // sw r8,8(r0)
    writeInstr(10, encI(35, 0, 9, 8));         // lw r9,8(r0)
    writeInstr(11, encI(8, 0, 10, 16));        // addi r10,r0,16
    writeInstr(12, encI(43, 10, 4, -4));       // sw r4,-4(r10)
    writeInstr(13, encI(35, 0, 11, 12));       // lw r11,12(r0)
    writeInstr(14, encI(8, 0, 0, 7));          // addi r0,r0,7
    writeInstr(15, encI(4, 1, 1, 1));          // beq taken
    writeInstr(16, encI(8, 0, 12, 99));        // skipped
    writeInstr(17, encI(5, 1, 1, 1));          // bne not taken
    writeInstr(18, encI(8, 0, 13, 1));         // addi r13
    writeInstr(19, encJ(3, 25));               // jal 25
    writeInstr(20, encI(8, 0, 14, 16'h55));    // addi r14
    writeInstr(21, encJ(2, 30));               // j 30
    writeInstr(22, encI(8, 0, 16, 1));         // skipped
    writeInstr(25, encI(8, 0, 15, 7));         // addi r15
    writeInstr(26, 32'hFC22_0001);             // undefined opcode 63
    writeInstr(27, {6'd0, 5'd1, 5'd1, 5'd17, 5'd0, 6'd63}); // undefined funct
    writeInstr(28, encR(31, 0, 0, 8));         // jr r31
    writeInstr(30, encI(4, 0, 0, -1));         // self loop
    @(negedge clk);
    imemWe = 1'b0;

    pushPc(0, "R1");
    for (int i = 1; i <= 15; i++) pushPc(i, "R1");
    pushPc(17, "R7"); pushPc(18, "R7"); pushPc(19, "R1");
    pushPc(25, "R8"); pushPc(26, "R1"); pushPc(27, "R10"); pushPc(28, "R10");
    pushPc(20, "R9"); pushPc(21, "R1"); pushPc(30, "R8");
    pushPc(30, "R7"); pushPc(30, "R7");

    pushReg(0,  32'h0,        "R6");
    pushReg(1,  32'd5,        "R4");
    pushReg(2,  32'hFFFFFFFD, "R4");
    pushReg(3,  32'd2,        "R2");
    pushReg(4,  32'hFFFFFFF8, "R2");
    pushReg(5,  32'd1,        "R3");
    pushReg(6,  32'd0,        "R3");
    pushReg(7,  32'd1,        "R3");
    pushReg(8,  32'h12348765, "R4");
    pushReg(9,  32'h12348765, "R5");
    pushReg(10, 32'd16,       "R4");
    pushReg(11, 32'hFFFFFFF8, "R5");
    pushReg(12, 32'd0,        "R7");
    pushReg(13, 32'd1,        "R7");
    pushReg(14, 32'h55,       "R9");
    pushReg(15, 32'd7,        "R8");
    pushReg(16, 32'd0,        "R8");
    pushReg(17, 32'd0,        "R10");
    pushReg(31, 32'd80,       "R8");
  endtask

  // monitor: PC trace one item per falling edge, then debug-port registers
  task automatic monitor();
    while (pcQ.size() > 0) begin
      item_t it = pcQ.pop_front();
      compare($sformatf("pc step to word %0d", it.idx), it.tag, pcOut, it.val);
      if (pcQ.size() > 0) @(negedge clk);
    end
    while (regQ.size() > 0) begin
      item_t it = regQ.pop_front();
      dbgRegSel = 5'(it.idx);
      #1;
      compare($sformatf("r%0d via debug port R11", it.idx), it.tag, dbgRegData, it.val);
    end
  endtask

  initial begin
    loadProgram();
    @(negedge clk);
    compare("pc held in reset", "R1", pcOut, 32'h0);
    rst = 1'b0;
    monitor();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule